// File: doc/BRIEF.md
# Quasi-Bidirectional Microcontroller I/O Ports

This block holds four 8-bit output latches that drive quasi-bidirectional pins. None of the ports has a direction register. A latch bit of 0 pulls its pin low. A latch bit of 1 releases the pin so that an outside source can set its level. This is why software turns a pin into an input by writing 1 to its latch. Ports 1, 2 and 3 add a weak pull-up to each released pin. Port 0 is open-drain: a released pin on port 0 has no internal source at all.

Software reaches the latches through an 8-bit register address. It can write a whole byte or a single bit. It can read either the latch contents or the pin levels, and pin levels pass through a two-flop synchronizer first. The port 3 outputs are combined with eight alternate-function outputs:

- bit 0 serial receive
- bit 1 serial transmit
- bits 2 and 3 interrupt inputs
- bits 4 and 5 counter inputs
- bit 6 write strobe
- bit 7 read strobe

An external memory override lets ports 0 and 2 carry low and high address bytes instead of their latch values.

Each pin is shown outside the block as two enables: a strong drive-low and a weak pull-up. The pin level is resolved outside the block and comes back in as `pin_in`.

Top module: `qbio_ports`

## Requirements
- R1: After reset every latch holds FFh, no `drv_low` bit is set, and `pull_up` equals FFFF_FF00h.
- R2: A byte write to address 80h, 90h, A0h or B0h loads port 0, 1, 2 or 3 respectively. The new value can be read as a latch read after the next rising edge. A byte write to any other address changes no latch.
- R3: A bit write to an address whose bits [7:3] select a port (10000b for port 0, 10010b for port 1, 10100b for port 2, 10110b for port 3) changes only the bit at index addr[2:0] of that port.
- R4: When a byte write and a bit write target the same port in the same cycle, the bit write sets its bit and the byte write supplies all the other bits.
- R5: An effective output bit of 0 sets `drv_low` and clears `pull_up` for that pin, and no pin ever has both set.
- R6: An effective output bit of 1 clears `drv_low`. On ports 1 to 3 it also sets `pull_up`. On port 0 (bits 7:0) it leaves both clear.
- R7: A pin read (`rd_latch`=0) returns `pin_in` as it was two rising edges earlier. A read at only one edge after a change still shows the old level.
- R8: A pin whose latch bit is 1 and that is driven low from outside reads 0 as a pin read and 1 as a latch read.
- R9: The effective output of port 3 is its latch ANDed bitwise with `alt_out`. `alt_out` is FFh when no alternate function is in use.
- R10: While `xmem_en` is 1, the effective outputs of port 0 and port 2 are `xmem_lo` and `xmem_hi`. The latches keep their values.
- R11: A read of an address that names no port returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write register address |
| wr_data | input | 8 | Byte write data |
| bw_en | input | 1 | Bit write strobe |
| bw_addr | input | 8 | Bit address: port select in [7:3], bit index in [2:0] |
| bw_val | input | 1 | Bit write value |
| rd_addr | input | 8 | Read register address |
| rd_latch | input | 1 | 1 reads the latch, 0 reads the synchronized pins |
| rd_data | output | 8 | Read data, combinational from the address |
| pin_in | input | 32 | Resolved pin levels, port n in bits 8n+7:8n |
| alt_out | input | 8 | Port 3 alternate-function outputs, idle 1 |
| xmem_en | input | 1 | External memory override for ports 0 and 2 |
| xmem_lo | input | 8 | Override value for port 0 |
| xmem_hi | input | 8 | Override value for port 2 |
| drv_low | output | 32 | Strong pull-down enable per pin |
| pull_up | output | 32 | Weak pull-up enable per pin |

## Verification
The timing of each result sets where the bench samples it:

- **Writes.** A byte or bit write appears in latch reads and in `drv_low`/`pull_up` just after the rising edge that takes it. The bench drives each write at a falling edge and checks one nanosecond after the following rising edge.
- **Alternate function and override.** `alt_out` and the external memory override have no register on their path. They are checked in the same cycle, after the inputs settle.
- **Pin reads.** These lag `pin_in` by two edges. The bench changes the pin at a falling edge, checks after one edge that the old level is still read, and checks after the second edge that the new level is read.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
    localparam int PW = 8;                    // pins per port
    localparam int NP = 4;                    // number of ports
    localparam int AW = 8;                    // register address width
    localparam int BI = $clog2(PW);           // bit index width
    localparam int TW = PW * NP;              // total pins
    localparam logic [AW-1:0] BASE   = 8'h80; // address of port 0
    localparam logic [AW-1:0] STRIDE = 8'h10; // address step between ports
    localparam logic [NP-1:0] PULLUP_MASK = 4'b1110;
    localparam int ALT_PORT = 3;
    localparam int XLO_PORT = 0;
    localparam int XHI_PORT = 2;

    typedef logic [PW-1:0] pbyte_t;

    typedef struct packed {
        pbyte_t [NP-1:0] latch;
    } bank_t;

    typedef struct packed {
        logic [TW-1:0] meta;
        logic [TW-1:0] sync;
        logic [1:0]    seen;
    } sync_t;
endpackage

// File: rtl/qbio_decode.sv
module qbio_decode
    import qbio_pkg::*;
(
    input  logic [AW-1:0] addr,
    output logic [NP-1:0] byte_sel,
    output logic [NP-1:0] bit_sel
);
    for (genvar gi = 0; gi < NP; gi++) begin : g_dec
        localparam logic [AW-1:0] PADDR = BASE + STRIDE * AW'(gi);
        assign byte_sel[gi] = (addr == PADDR);
        assign bit_sel[gi]  = (addr[AW-1:BI] == PADDR[AW-1:BI]);
    end
endmodule

// File: rtl/qbio_latch_bank.sv
module qbio_latch_bank
    import qbio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [NP-1:0] byte_sel,
    input  pbyte_t        byte_data,
    input  logic          bit_we,
    input  logic [NP-1:0] bit_sel,
    input  logic [BI-1:0] bit_idx,
    input  logic          bit_val,
    output bank_t         bank_q
);
    bank_t bank_d;

    always_comb begin
        bank_d = bank_q;
        for (int p = 0; p < NP; p++) begin
            if (byte_we && byte_sel[p]) bank_d.latch[p] = byte_data;
            if (bit_we && bit_sel[p])   bank_d.latch[p][bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '1;
        else        bank_q <= bank_d;
    end

    for (genvar gp = 0; gp < NP; gp++) begin : g_chk
        // R2
        byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_we && byte_sel[gp] && !(bit_we && bit_sel[gp]))
            |=> bank_q.latch[gp] == $past(byte_data));
        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(byte_we && byte_sel[gp]) && !(bit_we && bit_sel[gp]))
            |=> $stable(bank_q.latch[gp]));
        // R4
        bit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_we && bit_sel[gp])
            |=> bank_q.latch[gp][$past(bit_idx)] == $past(bit_val));
    end
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync
    import qbio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] pin_in,
    output logic [TW-1:0] pin_sync
);
    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_in;
        st_d.sync = st_q.meta;
        if (st_q.seen != 2'd2) st_d.seen = st_q.seen + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{meta: '1, sync: '1, seen: 2'd0};
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.sync;

    // R7
    two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seen == 2'd2) |-> pin_sync == $past(pin_in, 2));
endmodule

// File: rtl/qbio_pad_ctrl.sv
module qbio_pad_ctrl
    import qbio_pkg::*;
(
    input  bank_t         bank,
    input  pbyte_t        alt_out,
    input  logic          xmem_en,
    input  pbyte_t        xmem_lo,
    input  pbyte_t        xmem_hi,
    output logic [TW-1:0] drv_low,
    output logic [TW-1:0] pull_up
);
    for (genvar gp = 0; gp < NP; gp++) begin : g_pad
        pbyte_t eff;
        if (gp == ALT_PORT) begin : g_alt
            assign eff = bank.latch[gp] & alt_out;
        end else if (gp == XLO_PORT) begin : g_xlo
            assign eff = xmem_en ? xmem_lo : bank.latch[gp];
        end else if (gp == XHI_PORT) begin : g_xhi
            assign eff = xmem_en ? xmem_hi : bank.latch[gp];
        end else begin : g_plain
            assign eff = bank.latch[gp];
        end
        assign drv_low[gp*PW +: PW] = ~eff;
        if (PULLUP_MASK[gp]) begin : g_pu
            assign pull_up[gp*PW +: PW] = eff;
        end else begin : g_od
            assign pull_up[gp*PW +: PW] = '0;
        end
    end
endmodule

// File: rtl/qbio_ports.sv
module qbio_ports
    import qbio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          bw_en,
    input  logic [7:0]    bw_addr,
    input  logic          bw_val,
    input  logic [7:0]    rd_addr,
    input  logic          rd_latch,
    output logic [7:0]    rd_data,
    input  logic [31:0]   pin_in,
    input  logic [7:0]    alt_out,
    input  logic          xmem_en,
    input  logic [7:0]    xmem_lo,
    input  logic [7:0]    xmem_hi,
    output logic [31:0]   drv_low,
    output logic [31:0]   pull_up
);
    logic [NP-1:0] wr_sel, bw_sel, rd_sel;
    logic [NP-1:0] wr_unused, bw_unused, rd_unused;
    logic [TW-1:0] pin_sync;
    bank_t         bank;

    qbio_decode u_wr_dec (.addr(wr_addr), .byte_sel(wr_sel),    .bit_sel(wr_unused));
    qbio_decode u_bw_dec (.addr(bw_addr), .byte_sel(bw_unused), .bit_sel(bw_sel));
    qbio_decode u_rd_dec (.addr(rd_addr), .byte_sel(rd_sel),    .bit_sel(rd_unused));

    qbio_latch_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .byte_we(wr_en), .byte_sel(wr_sel), .byte_data(wr_data),
        .bit_we(bw_en), .bit_sel(bw_sel), .bit_idx(bw_addr[BI-1:0]),
        .bit_val(bw_val), .bank_q(bank)
    );

    qbio_sync u_sync (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync));

    qbio_pad_ctrl u_pad (
        .bank(bank), .alt_out(alt_out), .xmem_en(xmem_en),
        .xmem_lo(xmem_lo), .xmem_hi(xmem_hi),
        .drv_low(drv_low), .pull_up(pull_up)
    );

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NP; p++) begin
            if (rd_sel[p]) rd_data = rd_latch ? bank.latch[p] : pin_sync[p*PW +: PW];
        end
    end

    // R5
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_low & pull_up) == '0);
    // R10
    xmem_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmem_en |-> (drv_low[XLO_PORT*PW +: PW] == ~xmem_lo &&
                     drv_low[XHI_PORT*PW +: PW] == ~xmem_hi));
    // R6
    od_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_up[PW-1:0] == '0);
endmodule

// File: tb/tb_qbio_ports.sv
`timescale 1ns/1ps
module tb_qbio_ports;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, bw_en = 0, bw_val = 0, rd_latch = 1, xmem_en = 0;
    logic [7:0]  wr_addr = 0, wr_data = 0, bw_addr = 0, rd_addr = 8'h80;
    logic [7:0]  alt_out = 8'hFF, xmem_lo = 0, xmem_hi = 0;
    logic [7:0]  rd_data;
    logic [31:0] pin_in, drv_low, pull_up;
    logic [31:0] ext_en = 0, ext_val = 0;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // pin resolution: strong low, then outside driver, then weak pull-up, float reads 0
    always_comb begin
        for (int i = 0; i < 32; i++)
            pin_in[i] = drv_low[i] ? 1'b0 : ext_en[i] ? ext_val[i] : pull_up[i];
    end

    qbio_ports dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic wr_bit(logic [7:0] a, logic v);
        @(negedge clk); bw_en = 1; bw_addr = a; bw_val = v;
        @(posedge clk); #1; bw_en = 0;
    endtask

    task automatic rd(logic [7:0] a, logic lat, output logic [7:0] d);
        rd_addr = a; rd_latch = lat; #0.5; d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int p = 0; p < 4; p++) begin
            rd(8'h80 + 8'(p) * 8'h10, 1, d); chk("R1 latch", {24'h0, d}, 32'hFF);
        end
        chk("R1 drv_low", drv_low, 32'h0);
        chk("R1 pull_up", pull_up, 32'hFFFF_FF00);
    endtask

    task automatic t_byte();
        logic [7:0] d;
        wr_byte(8'h90, 8'hA5);
        rd(8'h90, 1, d); chk("R2 p1 latch", {24'h0, d}, 32'hA5);
        chk("R5 p1 drv_low", {24'h0, drv_low[15:8]}, 32'h5A);
        chk("R5 p1 pull_up", {24'h0, pull_up[15:8]}, 32'hA5);
        wr_byte(8'h85, 8'h00);
        rd(8'h80, 1, d); chk("R2 ignored addr p0", {24'h0, d}, 32'hFF);
        rd(8'h90, 1, d); chk("R2 ignored addr p1", {24'h0, d}, 32'hA5);
        rd(8'h85, 1, d); chk("R11 unmapped read", {24'h0, d}, 32'h00);
        rd(8'hC0, 0, d); chk("R11 unmapped pin read", {24'h0, d}, 32'h00);
    endtask

    task automatic t_bit();
        logic [7:0] d;
        wr_bit(8'hA3, 1'b0);
        rd(8'hA0, 1, d); chk("R3 p2 bit3", {24'h0, d}, 32'hF7);
        wr_bit(8'hB7, 1'b0);
        rd(8'hB0, 1, d); chk("R3 p3 bit7", {24'h0, d}, 32'h7F);
        rd(8'hA0, 1, d); chk("R3 p2 untouched", {24'h0, d}, 32'hF7);
        wr_bit(8'hA3, 1'b1);
        rd(8'hA0, 1, d); chk("R3 p2 bit3 set", {24'h0, d}, 32'hFF);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        wr_en = 1; wr_addr = 8'hB0; wr_data = 8'h00;
        bw_en = 1; bw_addr = 8'hB2; bw_val = 1'b1;
        @(posedge clk); #1; wr_en = 0; bw_en = 0;
        rd(8'hB0, 1, d); chk("R4 bit over byte", {24'h0, d}, 32'h04);
    endtask

    task automatic t_drive();
        wr_byte(8'h80, 8'hFF);
        wr_byte(8'h90, 8'hFF);
        chk("R6 p0 float drv", {24'h0, drv_low[7:0]}, 32'h0);
        chk("R6 p0 no pull", {24'h0, pull_up[7:0]}, 32'h0);
        chk("R6 p1 pull", {24'h0, pull_up[15:8]}, 32'hFF);
        wr_byte(8'h80, 8'h0F);
        chk("R5 p0 low half", {24'h0, drv_low[7:0]}, 32'hF0);
    endtask

    task automatic t_pin();
        logic [7:0] d;
        wr_byte(8'h90, 8'hFF);
        repeat (2) @(posedge clk);
        @(negedge clk); ext_en[9] = 1; ext_val[9] = 0;
        @(posedge clk); #1;
        rd(8'h90, 0, d); chk("R7 one edge old", {24'h0, d}, 32'hFF);
        @(posedge clk); #1;
        rd(8'h90, 0, d); chk("R7 R8 pin low", {24'h0, d}, 32'hFD);
        rd(8'h90, 1, d); chk("R8 latch high", {24'h0, d}, 32'hFF);
        @(negedge clk); ext_en = 0;
        repeat (2) @(posedge clk); #1;
        rd(8'h90, 0, d); chk("R7 released", {24'h0, d}, 32'hFF);
    endtask

    task automatic t_alt();
        wr_byte(8'hB0, 8'hFF);
        @(negedge clk); alt_out = 8'hFD; #1;
        chk("R9 tx low", {24'h0, drv_low[31:24]}, 32'h02);
        alt_out = 8'hFF; #1;
        wr_byte(8'hB0, 8'h7F);
        chk("R9 alt idle", {24'h0, drv_low[31:24]}, 32'h80);
        @(negedge clk); alt_out = 8'hFE; #1;
        chk("R9 and", {24'h0, drv_low[31:24]}, 32'h81);
        alt_out = 8'hFF;
    endtask

    task automatic t_xmem();
        logic [7:0] d;
        wr_byte(8'h80, 8'h11);
        wr_byte(8'hA0, 8'h22);
        @(negedge clk); xmem_en = 1; xmem_lo = 8'h3C; xmem_hi = 8'hC3; #1;
        chk("R10 p0", {24'h0, drv_low[7:0]}, 32'hC3);
        chk("R10 p2", {24'h0, drv_low[23:16]}, 32'h3C);
        chk("R10 p2 pull", {24'h0, pull_up[23:16]}, 32'hC3);
        @(posedge clk); #1;
        @(negedge clk); xmem_en = 0; #1;
        rd(8'h80, 1, d); chk("R10 p0 latch kept", {24'h0, d}, 32'h11);
        rd(8'hA0, 1, d); chk("R10 p2 latch kept", {24'h0, d}, 32'h22);
        chk("R10 p0 back", {24'h0, drv_low[7:0]}, 32'hEE);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_byte();
        t_bit();
        t_collide();
        t_drive();
        t_pin();
        t_alt();
        t_xmem();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule